// File: doc/BRIEF.md
# Plug-and-Play Card Configuration Sequencer

This block is the card-side control logic of a legacy plug-and-play expansion card. It watches host I/O writes to two fixed ports: an index port that selects a configuration register, and a data port that writes the selected register. From these writes it moves the card through four states: waiting for the initiation key, asleep, isolating and configuring. It also keeps the card select number, the current logical device number and the relocatable read-port address.

Once the card is out of the key-wait state, a write to the data port is decoded as a card-level command. The commands set the read port, wake a card by its select number, assign a select number after the card has won isolation, choose a logical device, or apply one of three self-clearing control actions. The read-port address, the state and the numbers feed the rest of the card. Two one-cycle pulses tell the logical devices to restore their power-up configuration and tell the resource-data reader to rewind its byte pointer.

Top module: `pnp_card_seq`

## Requirements
- R1: After reset, card_state is 0 (encoding: 0 key wait, 1 sleep, 2 isolation, 3 config), csn and ldn are 0, rd_port is 0x003, and both pulses are low.
- R2: In key wait, each index-port write is compared with the next expected key byte. The first byte is 0x6A and each later byte is {b[1]^b[0], b[7:1]} of the one before. A wrong byte restarts the match and is not counted as a first byte. After KEY_LEN (32) correct bytes in a row, the card is in sleep on the next cycle.
- R3: In key wait, data-port writes and writes to any other address change no output.
- R4: Outside key wait, a data write with index 0x00 sets rd_port to {data, 2'b11}.
- R5: A data write with index 0x03 whose data equals csn sends the card to isolation if the data is zero and to config if it is not. ptr_reset is then high for exactly the following cycle.
- R6: A data write with index 0x03 whose data differs from csn puts the card in sleep, and ptr_reset stays low.
- R7: A data write with index 0x06 in isolation while isol_won is high loads csn with the data and moves the card to config. In any other case the write has no effect.
- R8: A data write with index 0x02 and bit 2 set clears csn to 0.
- R9: A data write with index 0x02 and bit 1 set returns the card to key wait and keeps csn and ldn.
- R10: A data write with index 0x02 and bit 0 set raises ld_reset for exactly one cycle and keeps csn and the state. The control bits do not persist, so a later write to index 0x02 with zero data has no effect.
- R11: A data write with index 0x07 in config loads ldn when the data is below NUM_LD. Larger values and writes in other states are ignored. With NUM_LD = 1, ldn always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | AW (12) | Host I/O address |
| io_wr | input | 1 | Host write strobe, one cycle per write |
| io_wdata | input | 8 | Host write data |
| isol_won | input | 1 | The card has won serial isolation |
| card_state | output | 2 | Current state (0 key wait, 1 sleep, 2 isolation, 3 config) |
| csn | output | 8 | Card select number |
| ldn | output | 8 | Selected logical device number |
| rd_port | output | 10 | Read-port I/O address |
| ld_reset | output | 1 | Pulse: logical devices restore their power-up configuration |
| ptr_reset | output | 1 | Pulse: rewind the resource-data byte pointer |

## Verification
The assertions assume that a data write decodes to at most one command, since only one index is selected at a time. They also assume that isol_won is a level that only matters on a select-number write. The stimulus uses single-cycle write strobes separated by an idle cycle and changes isol_won only between writes. Random writes pick the index and data with a bias toward the current csn, zero and the control bits, so that every state is reached and left. Full key sequences, including some with a wrong byte partway through, are inserted among them.

// File: rtl/pnp_pkg.sv
package pnp_pkg;
  typedef enum logic [1:0] {
    ST_WAIT_KEY = 2'd0,
    ST_SLEEP    = 2'd1,
    ST_ISOLATE  = 2'd2,
    ST_CONFIG   = 2'd3
  } card_state_e;

  localparam logic [7:0] IDX_RDPORT = 8'h00;
  localparam logic [7:0] IDX_CTRL   = 8'h02;
  localparam logic [7:0] IDX_WAKE   = 8'h03;
  localparam logic [7:0] IDX_CSN    = 8'h06;
  localparam logic [7:0] IDX_LDN    = 8'h07;

  // one LFSR step of the initiation key
  function automatic logic [7:0] key_next(input logic [7:0] b);
    return {b[1] ^ b[0], b[7:1]};
  endfunction

  // read-port address from the programmed byte
  function automatic logic [9:0] rdport_addr(input logic [7:0] d);
    return {d, 2'b11};
  endfunction
endpackage

// File: rtl/pnp_key_match.sv
module pnp_key_match #(
  parameter int unsigned KEY_LEN  = 32,
  parameter logic [7:0]  KEY_SEED = 8'h6A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       armed,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       key_done
);
  import pnp_pkg::*;
  localparam int CW = $clog2(KEY_LEN + 1);

  logic [CW-1:0] idx_q;
  logic [7:0]    exp_q;
  logic          byte_hit;
  logic          last_byte;

  assign byte_hit  = armed && idx_wr && (wdata == exp_q);
  assign last_byte = (idx_q == CW'(KEY_LEN - 1));
  assign key_done  = byte_hit && last_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      exp_q <= KEY_SEED;
    end else if (!armed || key_done) begin
      idx_q <= '0;
      exp_q <= KEY_SEED;
    end else if (idx_wr) begin
      if (byte_hit) begin
        idx_q <= idx_q + 1'b1;
        exp_q <= key_next(exp_q);
      end else begin
        idx_q <= '0;
        exp_q <= KEY_SEED;
      end
    end
  end

  // R2
  key_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q < CW'(KEY_LEN));
endmodule

// File: rtl/pnp_cmd_decode.sv
module pnp_cmd_decode #(
  parameter int unsigned    AW         = 12,
  parameter logic [AW-1:0]  INDEX_ADDR = 12'h279,
  parameter logic [AW-1:0]  DATA_ADDR  = 12'hA79
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] io_addr,
  input  logic          io_wr,
  input  logic [7:0]    io_wdata,
  input  logic          active,
  output logic          idx_wr,
  output logic          ev_rdport,
  output logic          ev_ctrl,
  output logic          ev_wake,
  output logic          ev_csn,
  output logic          ev_ldn
);
  import pnp_pkg::*;
  logic [7:0] index_q;
  logic       dat_wr;

  assign idx_wr = io_wr && (io_addr == INDEX_ADDR);
  assign dat_wr = io_wr && (io_addr == DATA_ADDR) && active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                index_q <= '0;
    else if (idx_wr && active) index_q <= io_wdata;
  end

  always_comb begin
    ev_rdport = dat_wr && (index_q == IDX_RDPORT);
    ev_ctrl   = dat_wr && (index_q == IDX_CTRL);
    ev_wake   = dat_wr && (index_q == IDX_WAKE);
    ev_csn    = dat_wr && (index_q == IDX_CSN);
    ev_ldn    = dat_wr && (index_q == IDX_LDN);
  end

  // R3
  ev_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_rdport, ev_ctrl, ev_wake, ev_csn, ev_ldn}));
endmodule

// File: rtl/pnp_state_ctl.sv
module pnp_state_ctl (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 key_done,
  input  logic                 ev_rdport,
  input  logic                 ev_ctrl,
  input  logic                 ev_wake,
  input  logic                 ev_csn,
  input  logic [7:0]           wdata,
  input  logic                 isol_won,
  output pnp_pkg::card_state_e state_q,
  output logic [7:0]           csn_q,
  output logic [7:0]           rdbyte_q,
  output logic                 ld_reset_q,
  output logic                 ptr_reset_q
);
  import pnp_pkg::*;
  card_state_e st_d;
  logic [7:0]  csn_d;
  logic        wake_hit;
  logic        csn_take;

  assign wake_hit = ev_wake && (wdata == csn_q);
  assign csn_take = ev_csn && (state_q == ST_ISOLATE) && isol_won;

  always_comb begin
    st_d  = state_q;
    csn_d = csn_q;
    if (key_done) st_d = ST_SLEEP;
    if (ev_wake) begin
      if (wake_hit) st_d = (wdata == 8'h00) ? ST_ISOLATE : ST_CONFIG;
      else          st_d = ST_SLEEP;
    end
    if (csn_take) begin
      csn_d = wdata;
      st_d  = ST_CONFIG;
    end
    if (ev_ctrl) begin
      if (wdata[2]) csn_d = 8'h00;
      if (wdata[1]) st_d  = ST_WAIT_KEY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_WAIT_KEY;
      csn_q       <= '0;
      rdbyte_q    <= '0;
      ld_reset_q  <= 1'b0;
      ptr_reset_q <= 1'b0;
    end else begin
      state_q     <= st_d;
      csn_q       <= csn_d;
      if (ev_rdport) rdbyte_q <= wdata;
      ld_reset_q  <= ev_ctrl && wdata[0];
      ptr_reset_q <= wake_hit;
    end
  end

  // R2
  wait_key_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT_KEY) |=> (state_q inside {ST_WAIT_KEY, ST_SLEEP}));
  // R7
  csn_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_csn || ev_ctrl) |=> $stable(csn_q));
  // R5
  ptr_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_reset_q |-> $past(ev_wake));
  // R10
  ld_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_reset_q |-> $past(ev_ctrl));
endmodule

// File: rtl/pnp_ldn_sel.sv
module pnp_ldn_sel #(
  parameter int unsigned NUM_LD = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ev_ldn,
  input  pnp_pkg::card_state_e state_q,
  input  logic [7:0]           wdata,
  output logic [7:0]           ldn
);
  import pnp_pkg::*;
  generate
    if (NUM_LD <= 1) begin : g_single
      assign ldn = 8'h00;
    end else begin : g_multi
      logic [7:0] ldn_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ldn_q <= '0;
        else if (ev_ldn && (state_q == ST_CONFIG) && ({24'd0, wdata} < NUM_LD))
          ldn_q <= wdata;
      end
      assign ldn = ldn_q;
      // R11
      ldn_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        {24'd0, ldn_q} < NUM_LD);
    end
  endgenerate
endmodule

// File: rtl/pnp_card_seq.sv
module pnp_card_seq #(
  parameter int unsigned   AW         = 12,
  parameter logic [AW-1:0] INDEX_ADDR = 12'h279,
  parameter logic [AW-1:0] DATA_ADDR  = 12'hA79,
  parameter int unsigned   KEY_LEN    = 32,
  parameter logic [7:0]    KEY_SEED   = 8'h6A,
  parameter int unsigned   NUM_LD     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] io_addr,
  input  logic          io_wr,
  input  logic [7:0]    io_wdata,
  input  logic          isol_won,
  output logic [1:0]    card_state,
  output logic [7:0]    csn,
  output logic [7:0]    ldn,
  output logic [9:0]    rd_port,
  output logic          ld_reset,
  output logic          ptr_reset
);
  import pnp_pkg::*;
  card_state_e st;
  logic idx_wr, key_done;
  logic ev_rdport, ev_ctrl, ev_wake, ev_csn, ev_ldn;
  logic [7:0] rdbyte;

  pnp_key_match #(.KEY_LEN(KEY_LEN), .KEY_SEED(KEY_SEED)) u_key (
    .clk(clk), .rst_n(rst_n), .armed(st == ST_WAIT_KEY),
    .idx_wr(idx_wr), .wdata(io_wdata), .key_done(key_done));

  pnp_cmd_decode #(.AW(AW), .INDEX_ADDR(INDEX_ADDR), .DATA_ADDR(DATA_ADDR)) u_dec (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
    .io_wdata(io_wdata), .active(st != ST_WAIT_KEY), .idx_wr(idx_wr),
    .ev_rdport(ev_rdport), .ev_ctrl(ev_ctrl), .ev_wake(ev_wake),
    .ev_csn(ev_csn), .ev_ldn(ev_ldn));

  pnp_state_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .key_done(key_done), .ev_rdport(ev_rdport),
    .ev_ctrl(ev_ctrl), .ev_wake(ev_wake), .ev_csn(ev_csn), .wdata(io_wdata),
    .isol_won(isol_won), .state_q(st), .csn_q(csn), .rdbyte_q(rdbyte),
    .ld_reset_q(ld_reset), .ptr_reset_q(ptr_reset));

  pnp_ldn_sel #(.NUM_LD(NUM_LD)) u_ldn (
    .clk(clk), .rst_n(rst_n), .ev_ldn(ev_ldn), .state_q(st),
    .wdata(io_wdata), .ldn(ldn));

  assign card_state = st;
  assign rd_port    = rdport_addr(rdbyte);
endmodule

// File: tb/tb_pnp_card_seq.sv
module tb_pnp_card_seq;
  localparam int KEY_LEN = 32;
  localparam int NUM_LD  = 4;
  localparam logic [11:0] IDXA = 12'h279, DATA = 12'hA79;

  logic clk = 0, rst_n = 0, io_wr = 0, isol_won = 0;
  logic [11:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic [1:0]  card_state;
  logic [7:0]  csn, ldn, ldn1;
  logic [9:0]  rd_port;
  logic        ld_reset, ptr_reset;
  logic [1:0]  st1;
  logic [7:0]  csn1;
  logic [9:0]  rdp1;
  logic        ldr1, ptr1;

  always #2 clk = ~clk;

  pnp_card_seq #(.KEY_LEN(KEY_LEN), .NUM_LD(NUM_LD)) dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
    .io_wdata(io_wdata), .isol_won(isol_won), .card_state(card_state),
    .csn(csn), .ldn(ldn), .rd_port(rd_port), .ld_reset(ld_reset),
    .ptr_reset(ptr_reset));

  pnp_card_seq #(.KEY_LEN(KEY_LEN), .NUM_LD(1)) dut1 (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
    .io_wdata(io_wdata), .isol_won(isol_won), .card_state(st1),
    .csn(csn1), .ldn(ldn1), .rd_port(rdp1), .ld_reset(ldr1),
    .ptr_reset(ptr1));

  int checks = 0, failures = 0;
  bit done = 0;

  // model
  int m_st = 0, m_kidx = 0, m_idx = 0;
  logic [7:0] m_csn = 0, m_ldn = 0, m_rdb = 0;
  bit m_ldr = 0, m_ptr = 0;

  function automatic logic [7:0] keyb(int n);
    int b = 'h6A;
    for (int i = 0; i < n; i++) b = (b >> 1) | (((b ^ (b >> 1)) & 1) << 7);
    return b[7:0];
  endfunction

  function automatic logic [9:0] exp_rdp(logic [7:0] d);
    return 10'(d) * 10'd4 + 10'd3;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_wr(logic [11:0] a, logic [7:0] d);
    m_ldr = 0; m_ptr = 0;
    if (a == IDXA) begin
      if (m_st == 0) begin
        if (d == keyb(m_kidx)) begin
          m_kidx++;
          if (m_kidx == KEY_LEN) begin m_st = 1; m_kidx = 0; end
        end else m_kidx = 0;
      end else m_idx = d;
    end else if (a == DATA && m_st != 0) begin
      case (m_idx)
        0: m_rdb = d;
        2: begin
          if (d[2]) m_csn = 0;
          if (d[1]) begin m_st = 0; m_kidx = 0; end
          if (d[0]) m_ldr = 1;
        end
        3: if (d == m_csn) begin m_st = (d == 0) ? 2 : 3; m_ptr = 1; end
           else m_st = 1;
        6: if (m_st == 2 && isol_won) begin m_csn = d; m_st = 3; end
        7: if (m_st == 3 && d < NUM_LD) m_ldn = d;
        default: ;
      endcase
    end
  endtask

  task automatic check_all(string req);
    chk(req, "state", card_state, m_st);
    chk(req, "csn", csn, m_csn);
    chk(req, "ldn", ldn, m_ldn);
    chk(req, "rd_port", rd_port, exp_rdp(m_rdb));
    chk(req, "ld_reset", ld_reset, m_ldr);
    chk(req, "ptr_reset", ptr_reset, m_ptr);
    chk("R11", "single ldn", ldn1, 0);
  endtask

  task automatic wr(logic [11:0] a, logic [7:0] d, string req);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1;
    model_wr(a, d);
    @(negedge clk);
    io_wr = 0;
    check_all(req);
  endtask

  task automatic send_key(string req);
    for (int i = 0; i < KEY_LEN; i++) wr(IDXA, keyb(i), req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1;
    @(negedge clk);
    check_all("R1");

    // R3: data writes ignored while waiting for key
    wr(IDXA, 8'h00, "R3");
    wr(DATA, 8'h55, "R3");
    wr(12'h123, 8'h6A, "R3");
    // R2: broken key then full key
    for (int i = 0; i < 5; i++) wr(IDXA, keyb(i), "R2");
    wr(IDXA, 8'hFF, "R2");
    for (int i = 0; i < KEY_LEN - 1; i++) wr(IDXA, keyb(i), "R2");
    chk("R2", "not yet asleep", card_state, 0);
    wr(IDXA, keyb(KEY_LEN - 1), "R2");
    chk("R2", "asleep", card_state, 1);
    // R4
    wr(IDXA, 8'h00, "R4"); wr(DATA, 8'h8B, "R4");
    // R5 wake zero -> isolation, R7 csn load
    wr(IDXA, 8'h03, "R5"); wr(DATA, 8'h00, "R5");
    isol_won = 0;
    wr(IDXA, 8'h06, "R7"); wr(DATA, 8'h11, "R7");
    isol_won = 1;
    wr(DATA, 8'h11, "R7");
    isol_won = 0;
    // R11
    wr(IDXA, 8'h07, "R11"); wr(DATA, 8'h02, "R11"); wr(DATA, 8'h09, "R11");
    // R6, R5 nonzero
    wr(IDXA, 8'h03, "R6"); wr(DATA, 8'h22, "R6");
    wr(DATA, 8'h11, "R5");
    // R10, R8, R9
    wr(IDXA, 8'h02, "R10"); wr(DATA, 8'h01, "R10"); wr(DATA, 8'h00, "R10");
    wr(DATA, 8'h04, "R8");
    wr(DATA, 8'h02, "R9");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom_range(0, 99);
      isol_won = $urandom_range(0, 1);
      if (r < 4) send_key("R2");
      else if (r < 35) begin
        int p = $urandom_range(0, 6);
        logic [7:0] ix = (p == 0) ? 8'h00 : (p == 1) ? 8'h02 : (p == 2) ? 8'h03 :
                         (p == 3) ? 8'h06 : (p == 4) ? 8'h07 : 8'($urandom);
        wr(IDXA, ix, "R4");
      end else if (r < 95) begin
        int q = $urandom_range(0, 5);
        logic [7:0] d = (q == 0) ? m_csn : (q == 1) ? 8'h00 : (q == 2) ? 8'($urandom_range(0, 5)) :
                        (q == 3) ? ($urandom_range(0, 3) == 0 ? 8'h02 : 8'h05) : 8'($urandom);
        wr(DATA, d, (m_idx == 3) ? "R5" : (m_idx == 6) ? "R7" : (m_idx == 2) ? "R10" : "R11");
      end else wr(12'($urandom), 8'($urandom), "R3");
    end
    finish_run();
  end
endmodule